// File: doc/BRIEF.md
# Serial-Count Game of Life Cell Grid

This block holds a small two-dimensional grid of Game of Life cells and advances it one generation at a time under control of an 8-bit symbol stream. Rather than adding up eight neighbours in one parallel adder per cell, every cell has a tiny saturating counter that takes in one neighbour per counting symbol. There are eight counting steps in a fixed direction order. A closing compute symbol then applies the life rules to all cells at once.

Letter symbols seed live cells. Digit symbols form the instruction sequence. Two instruction dialects are supported and chosen by a mode input. In the standard dialect a generation is eight `1` symbols followed by one `0`. In the alternate dialect a generation is `0`, then `1` through `8`, then `0`. Here the leading `0` copies the grid into a shadow register, and counting reads that copy. The grid is visible as a packed vector, and a one-clock strobe marks each committed generation.

Top module: `life_grid`

## Requirements
- R1: After reset every cell is dead (`state` all zero) and `gen_done` is low.
- R2: A valid label symbol sets one cell alive at the next clock edge. Letters `a`..`z` name cells 0..25 and `A`..`Z` name cells 26..51. Cell (row, col) is index row*COLS+col and sits at bit index of `state`. A label whose index is not below ROWS*COLS leaves `state` unchanged.
- R3: In standard mode (`mode_alt`=0), eight `1` symbols followed by `0` replace the grid with its next generation at the edge that accepts the `0`. A dead cell with exactly three live neighbours becomes alive. A live cell with two or three live neighbours stays alive. All other cells become dead.
- R4: Positions outside the grid count as permanently dead neighbours.
- R5: Once a fourth live neighbour has been counted, the cell is dead after the generation, whatever its earlier count or state.
- R6: The neighbour counters are cleared at every generation commit, so consecutive generations are computed independently.
- R7: A digit other than the one expected next aborts the sequence. This includes a `0` before all eight counting symbols. The abort clears the counters, leaves `state` unchanged and produces no `gen_done`. The next complete sequence gives a correct generation.
- R8: A label symbol received in the middle of a sequence also aborts the sequence, besides setting its cell.
- R9: In alternate mode (`mode_alt`=1) the sequence `0`,`1`,`2`,...,`8`,`0` yields the same next generation as R3.
- R10: A change of `mode_alt` aborts any partial sequence. A sequence written in the other mode's dialect commits no generation.
- R11: `gen_done` is high for exactly one clock, in the cycle the new generation first appears on `state`, and only after a compute symbol.
- R12: Cycles with `sym_valid` low, and valid symbols that are neither letters nor digits, have no effect on the grid or on sequence progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Qualifies `sym` for this cycle |
| sym | input | 8 | Symbol: letter label or digit instruction |
| mode_alt | input | 1 | 0 = standard dialect, 1 = alternate dialect with shadow copy |
| state | output | ROWS*COLS | Live flag per cell, index row*COLS+col |
| gen_done | output | 1 | One-clock strobe when a generation commits |

## Verification
The compute edge does two jobs at once. Every cell evaluates the rules from its counter, and every counter is cleared. A fault in either is invisible after a single generation. The bench therefore runs generations back to back, including an oscillator brought back to its first phase, and compares each commit against a bench-side grid model. Stale counts or a missed clear would corrupt the second result. An aborted sequence followed at once by a complete one is judged the same way. It shows that an abort clears in the same cycle as it discards the partial count.

// File: rtl/life_pkg.sv
// Package: shared types and symbol/direction helpers for the life grid.
// Assumes an 8-bit symbol alphabet where digits are instructions and
// ASCII letters are cell labels.
package life_pkg;

    localparam int NDIR = 8;
    typedef logic [2:0] dir_t;

    // Classify a symbol as an instruction digit.
    function automatic logic is_digit(input logic [7:0] s);
        return (s >= 8'h30) && (s <= 8'h39);
    endfunction

    // Classify a symbol as a cell label letter.
    function automatic logic is_label(input logic [7:0] s);
        return ((s >= 8'h61) && (s <= 8'h7A)) || ((s >= 8'h41) && (s <= 8'h5A));
    endfunction

    // Map a label letter to a cell index (lower case first).
    function automatic int label_index(input logic [7:0] s);
        if (s >= 8'h61) return int'(s) - 97;
        return int'(s) - 65 + 26;
    endfunction

    // Row offset of direction d (0=N, clockwise through NW).
    function automatic int dir_dr(input int d);
        case (d)
            0, 1, 7: return -1;
            3, 4, 5: return 1;
            default: return 0;
        endcase
    endfunction

    // Column offset of direction d.
    function automatic int dir_dc(input int d);
        case (d)
            1, 2, 3: return 1;
            5, 6, 7: return -1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/life_seq.sv
// Sequencer: tracks the instruction sequence of either dialect and issues
// count, load, compute and clear strobes shared by every cell.
// Assumes one symbol per valid cycle; labels and wrong digits abort.
module life_seq
    import life_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [7:0] sym,
    input  logic       mode_alt,
    output logic       alt_q,
    output logic       count_en,
    output dir_t       dir,
    output logic       load_snap,
    output logic       compute,
    output logic       clear
);
    localparam int LAST_STD = NDIR;
    localparam int LAST_ALT = NDIR + 1;
    localparam int PH_W     = $clog2(LAST_ALT + 1);

    logic [PH_W-1:0] phase;
    logic [7:0]      exp_sym;
    logic            mode_chg, hit, miss, counting, at_last;

    // Decode what the current phase expects and classify this symbol.
    always_comb begin
        mode_chg = (mode_alt != alt_q);
        if (!alt_q) begin
            exp_sym  = (32'(phase) == LAST_STD) ? 8'h30 : 8'h31;
            counting = 32'(phase) < NDIR;
            at_last  = 32'(phase) == LAST_STD;
            dir      = 3'(phase);
        end else begin
            exp_sym  = (phase == '0 || 32'(phase) == LAST_ALT) ? 8'h30 : (8'h30 + 8'(phase));
            counting = (phase != '0) && (32'(phase) <= NDIR);
            at_last  = 32'(phase) == LAST_ALT;
            dir      = 3'(phase - PH_W'(1));
        end
        hit       = sym_valid && is_digit(sym) && (sym == exp_sym) && !mode_chg;
        miss      = mode_chg || (sym_valid && (is_label(sym) || (is_digit(sym) && sym != exp_sym)));
        count_en  = hit && counting;
        compute   = hit && at_last;
        load_snap = hit && alt_q && (phase == '0);
        clear     = miss || compute;
    end

    // Advance, wrap or abort the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase <= '0;
        else if (miss)       phase <= '0;
        else if (hit)        phase <= at_last ? '0 : phase + PH_W'(1);
    end

    // Register the selected dialect so a change is seen as an abort.
    always_ff @(posedge clk) begin
        if (!rst_n) alt_q <= 1'b0;
        else        alt_q <= mode_alt;
    end
endmodule

// File: rtl/life_cell.sv
// One grid cell: a serial neighbour counter with early kill, and the
// live flag updated by labels and by the compute strobe.
// Assumes at most one neighbour bit is offered per counting cycle.
module life_cell #(
    parameter int KILL_AT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_live,
    input  logic count_en,
    input  logic nb_live,
    input  logic self_ref,
    input  logic compute,
    input  logic clear,
    output logic alive
);
    localparam int CNT_W = $clog2(KILL_AT);
    localparam int BIRTH = 3;
    localparam int KEEP  = 2;

    logic [CNT_W-1:0] cnt;
    logic             killed;
    logic             next_alive;

    // Apply the life rules to the accumulated count.
    always_comb begin
        next_alive = !killed &&
                     ((cnt == CNT_W'(BIRTH)) || ((cnt == CNT_W'(KEEP)) && self_ref));
    end

    // Count live neighbours; the KILL_AT-th one latches the kill flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            killed <= 1'b0;
        end else if (count_en && nb_live && !killed) begin
            if (32'(cnt) == KILL_AT - 1) killed <= 1'b1;
            else                         cnt    <= cnt + CNT_W'(1);
        end
    end

    // Hold the live flag; labels seed, compute commits.
    always_ff @(posedge clk) begin
        if (!rst_n)        alive <= 1'b0;
        else if (set_live) alive <= 1'b1;
        else if (compute)  alive <= next_alive;
    end
endmodule

// File: rtl/life_grid.sv
// Top: ROWS x COLS life grid driven by a symbol stream. Wires each cell to
// its eight neighbours (dead beyond the edge), decodes labels, keeps the
// shadow copy for the alternate dialect and raises the generation strobe.
module life_grid
    import life_pkg::*;
#(
    parameter int ROWS = 6,
    parameter int COLS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sym_valid,
    input  logic [7:0]           sym,
    input  logic                 mode_alt,
    output logic [ROWS*COLS-1:0] state,
    output logic                 gen_done
);
    localparam int CELLS = ROWS * COLS;

    logic             alt_q, count_en, load_snap, compute, clear, lbl_ok;
    dir_t             dir;
    int               lbl_idx;
    logic [CELLS-1:0] snap, ref_v;

    life_seq u_seq (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .mode_alt(mode_alt), .alt_q(alt_q), .count_en(count_en), .dir(dir),
        .load_snap(load_snap), .compute(compute), .clear(clear)
    );

    // Decode a label that names an existing cell.
    always_comb begin
        lbl_idx = label_index(sym);
        lbl_ok  = sym_valid && is_label(sym) && (lbl_idx < CELLS);
        ref_v   = alt_q ? snap : state;
    end

    // Shadow copy taken by the leading symbol of the alternate dialect.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (load_snap) snap <= state;
    end

    // Generation strobe, aligned with the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) gen_done <= 1'b0;
        else        gen_done <= compute;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic [NDIR-1:0] nb_w;
            for (genvar d = 0; d < NDIR; d++) begin : g_dir
                localparam int SR = r - dir_dr(d);
                localparam int SC = c - dir_dc(d);
                if (SR >= 0 && SR < ROWS && SC >= 0 && SC < COLS) begin : g_in
                    assign nb_w[d] = ref_v[SR * COLS + SC];
                end else begin : g_edge
                    assign nb_w[d] = 1'b0;
                end
            end
            life_cell #(.KILL_AT(4)) u_cell (
                .clk(clk), .rst_n(rst_n),
                .set_live(lbl_ok && (lbl_idx == IDX)),
                .count_en(count_en), .nb_live(nb_w[dir]),
                .self_ref(ref_v[IDX]), .compute(compute), .clear(clear),
                .alive(state[IDX])
            );
        end
    end
endmodule

// File: rtl/life_grid_chk.sv
// Checker: temporal properties of the life grid ports, bound to the top.
module life_grid_chk
    import life_pkg::*;
#(
    parameter int ROWS = 6,
    parameter int COLS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sym_valid,
    input logic [7:0]           sym,
    input logic                 mode_alt,
    input logic [ROWS*COLS-1:0] state,
    input logic                 gen_done
);
    localparam int CELLS = ROWS * COLS;

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |=> !gen_done);

    // R11
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |-> ($past(sym_valid) && $past(sym) == 8'h30));

    // R2
    label_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && is_label(sym) && label_index(sym) < CELLS)
        |=> state[label_index($past(sym))]);

    // R12
    grid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (gen_done || ($past(sym_valid) && is_label($past(sym)))));

    // R10
    mode_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_alt != $past(mode_alt)) |=> !gen_done);
endmodule

bind life_grid life_grid_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .mode_alt(mode_alt), .state(state), .gen_done(gen_done)
);

// File: tb/test_life_grid.sv
// Scoreboard bench: driver tasks push expected grids, a monitor pops them
// on each generation strobe and compares with the design output.
module test_life_grid;
    localparam int  ROWS = 6;
    localparam int  COLS = 6;
    localparam int  N    = ROWS * COLS;
    localparam time TCLK = 10ns;

    logic         clk = 1'b0, rst_n = 1'b0, sym_valid = 1'b0, mode_alt = 1'b0;
    logic [7:0]   sym = 8'h00;
    logic [N-1:0] state;
    logic         gen_done;
    logic [N-1:0] model = '0;
    logic [N-1:0] expq[$];
    int checks = 0, errors = 0;

    life_grid #(.ROWS(ROWS), .COLS(COLS)) i_life_grid (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .mode_alt(mode_alt), .state(state), .gen_done(gen_done)
    );

    always #(TCLK/2) clk = ~clk;

    function automatic logic [N-1:0] life_next(input logic [N-1:0] s);
        logic [N-1:0] o = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                int n = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if ((dr != 0 || dc != 0) && r+dr >= 0 && r+dr < ROWS &&
                            c+dc >= 0 && c+dc < COLS)
                            n += int'(s[(r+dr)*COLS + c+dc]);
                o[r*COLS+c] = (n == 3) || (n == 2 && s[r*COLS+c]);
            end
        return o;
    endfunction

    function automatic logic [7:0] lbl(input int i);
        return (i < 26) ? 8'(97 + i) : 8'(65 + i - 26);
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        sym = b; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic seed(input int i);
        send(lbl(i));
        if (i < N) model[i] = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode_alt = 1'b0; idle(2); rst_n = 1'b1; model = '0; idle(1);
    endtask

    task automatic push_gen();
        model = life_next(model);
        expq.push_back(model);
    endtask

    // Standard dialect generation; also checks the strobe drops (R11).
    task automatic run_std();
        push_gen();
        repeat (8) send(8'h31);
        send(8'h30);
        @(negedge clk);
        chk("R11 strobe one clock", N'(gen_done), N'(0));
    endtask

    // Alternate dialect generation (R9).
    task automatic run_alt();
        push_gen();
        send(8'h30);
        for (int k = 1; k <= 8; k++) send(8'(8'h30 + k));
        send(8'h30);
        @(negedge clk);
        chk("R11 strobe one clock", N'(gen_done), N'(0));
    endtask

    // Monitor: pop and compare on each generation strobe.
    always @(negedge clk) begin
        if (rst_n && gen_done) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7/R11 unexpected gen_done state=%h expected=no strobe", state);
            end else begin
                chk("R3 generation result", state, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(2);
        chk("R1 reset state", state, '0);
        chk("R1 reset strobe", N'(gen_done), N'(0));
        do_reset();
        chk("R1 state after reset", state, '0);

        // R2/R3/R6: blinker, two back-to-back generations
        seed(13); seed(14); seed(15);
        chk("R2 labels seed", state, model);
        run_std(); run_std();
        chk("R6 blinker back to start", state, model);

        // R2: label beyond grid ignored
        send(lbl(36)); idle(1);
        chk("R2 out-of-range label", state, model);

        // R5: plus shape, centre has four neighbours
        do_reset();
        seed(8); seed(13); seed(14); seed(15); seed(20);
        run_std();
        chk("R5 kill at four", N'(state[14]), N'(0));

        // R4: corner L shapes at two corners
        do_reset();
        seed(0); seed(1); seed(6); seed(35); seed(34); seed(29);
        run_std(); run_std();
        chk("R4 edge dead", state, model);

        // R7: wrong digit aborts, early compute aborts
        do_reset();
        seed(13); seed(14); seed(15);
        repeat (5) send(8'h31);
        send(8'h35); send(8'h30); idle(2);
        chk("R7 abort keeps grid", state, model);
        repeat (3) send(8'h31);
        send(8'h30); idle(2);
        chk("R7 early compute", state, model);
        run_std();

        // R12: gaps and non-label non-digit symbols ignored mid-sequence
        push_gen();
        repeat (4) send(8'h31);
        send(8'h23); idle(2); send(8'h2A);
        repeat (4) send(8'h31);
        send(8'h30); idle(2);
        chk("R12 ignored symbols", state, model);

        // R8: label mid-sequence aborts
        repeat (4) send(8'h31);
        seed(0);
        repeat (4) send(8'h31);
        send(8'h30); idle(2);
        chk("R8 label aborts", state, model);
        run_std();

        // R9: alternate dialect
        mode_alt = 1'b1; idle(1);
        run_alt(); run_alt();
        chk("R9 alt generations", state, model);

        // R10: standard dialect in alternate mode, then mode flips
        repeat (8) send(8'h31);
        send(8'h30); idle(2);
        chk("R10 wrong dialect", state, model);
        mode_alt = 1'b0; idle(1);
        repeat (4) send(8'h31);
        mode_alt = 1'b1; idle(1);
        run_alt();

        idle(3);
        chk("R11 all strobes seen", N'(expq.size()), N'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule